// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block walks a linked list of receive descriptors kept in a word-addressed memory. Each time the receive datapath reports a completed frame (a byte count and four error flags), the engine reads the status word of the current descriptor. If the DMA side owns that descriptor, the engine writes a completion status into it and hands it back to the processor. It then fetches the descriptor's link word and uses it as the new current descriptor. The engine does not move payload bytes. Buffer filling is handled elsewhere.

A descriptor spans four consecutive words. The status word is at offset 0, the buffer address at offset 1, a spare word at offset 2 and the link word at offset 3. When the engine finds a descriptor that the processor still owns, it stalls and raises a descriptor-unavailable flag. It holds the frame that found no descriptor and waits for a poll-demand pulse, which makes it re-read the same descriptor. Frames that arrive while the engine is stalled or busy are dropped and counted in a saturating missed-frame counter. A rising edge on the receive enable copies the ring base address into the current-descriptor pointer.

Top module: `rxring_wb`

## Requirements
- R1: For an accepted frame, the engine first reads the status word at the current descriptor address. For an available descriptor, it then reads the link word at the current address plus 3. Memory reads return data one cycle after the request.
- R2: A descriptor is available only when bits 31:30 of its status word are 2'b10. The engine writes its status to the current address with bits 31:30 cleared to 2'b00 (processor-owned), bit 16 set (frame complete) and the frame byte count in bits 15:0.
- R3: In the written status, bit 17 flags a CRC error, bit 19 a frame that is too long, bit 21 an alignment error and bit 22 a runt frame. Bit 20 (good frame) is set only when none of the four errors is present. All other bits are zero.
- R4: After the writeback, the current-descriptor pointer takes the low address bits of the link word. The buffer word, the spare word and the link word of that descriptor are left unchanged.
- R5: When the status word read has any ownership value other than 2'b10, nothing is written, desc_unavail goes high and the pointer stays where it is.
- R6: While stalled, a poll_kick pulse re-reads the current descriptor. If the descriptor is now available, the held frame is written back, desc_unavail falls and the pointer advances. If it is still processor-owned, the engine stalls again.
- R7: A frame event that arrives while the engine is enabled but not idle is dropped. It increments miss_count, which holds at its maximum value once reached.
- R8: A 0-to-1 transition of rx_enable loads ring_base into the current-descriptor pointer. While rx_enable is low, frame events cause no memory access and are not counted.
- R9: Synchronous active-high reset clears the pointer, desc_unavail and miss_count, and the engine makes no memory request until a frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable; its rising edge loads ring_base |
| ring_base | input | AW | Word address of the first descriptor |
| poll_kick | input | 1 | Poll-demand strobe; restarts a stalled engine |
| frm_done | input | 1 | One-cycle frame-completion event |
| frm_len | input | 16 | Received byte count |
| frm_crc_err | input | 1 | CRC error flag |
| frm_too_long | input | 1 | Frame-too-long flag |
| frm_align_err | input | 1 | Alignment error flag |
| frm_runt | input | 1 | Runt frame flag |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd |
| desc_unavail | output | 1 | High while stalled on a processor-owned descriptor |
| cur_desc | output | AW | Current descriptor word address |
| miss_count | output | CNT_W | Saturating count of dropped frames |

## Verification
The bench builds the engine with AW=8 for a 256-word memory, which is large enough for a ring of four non-adjacent descriptors whose links run out of address order. That layout makes any fixed-stride pointer update visible. CNT_W is set to 4, so the missed-frame counter saturates after fifteen dropped frames and the saturation boundary can be checked in a short run during one stall. The same stall covers a poll that finds the descriptor still owned by the processor and a poll that finds it handed back.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int STAT_W    = 32;
    localparam int LEN_W     = 16;
    localparam int OFS_LINK  = 3;

    localparam int OWN_HI    = 31;
    localparam int OWN_LO    = 30;
    localparam logic [1:0] OWN_DMA = 2'b10;
    localparam logic [1:0] OWN_CPU = 2'b00;

    localparam int BIT_DONE  = 16;
    localparam int BIT_CRC   = 17;
    localparam int BIT_LONG  = 19;
    localparam int BIT_GOOD  = 20;
    localparam int BIT_ALIGN = 21;
    localparam int BIT_RUNT  = 22;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             crc;
        logic             too_long;
        logic             align;
        logic             runt;
    } frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_LINK,
        S_STALL
    } state_t;

    function automatic logic [STAT_W-1:0] wb_status(frame_t f);
        logic [STAT_W-1:0] s;
        s                   = '0;
        s[LEN_W-1:0]        = f.len;
        s[BIT_DONE]         = 1'b1;
        s[BIT_CRC]          = f.crc;
        s[BIT_LONG]         = f.too_long;
        s[BIT_ALIGN]        = f.align;
        s[BIT_RUNT]         = f.runt;
        s[BIT_GOOD]         = !(f.crc || f.too_long || f.align || f.runt);
        s[OWN_HI:OWN_LO]    = OWN_CPU;
        return s;
    endfunction

endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic          load_next,
    input  logic [AW-1:0] next_addr,
    output logic [AW-1:0] cur,
    output logic          armed
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (en && !en_q) begin
                cur <= base;
            end else if (load_next) begin
                cur <= next_addr;
            end
        end
    end

    assign armed = en && en_q;
endmodule

// File: rtl/rxring_miss.sv
module rxring_miss #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rxring_fmt.sv
module rxring_fmt
    import rxring_pkg::*;
(
    input  frame_t            frm,
    output logic [STAT_W-1:0] status
);
    always_comb begin
        status = wb_status(frm);
    end
endmodule

// File: rtl/rxring_wb.sv
module rxring_wb
    import rxring_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic [AW-1:0]     ring_base,
    input  logic              poll_kick,
    input  logic              frm_done,
    input  logic [15:0]       frm_len,
    input  logic              frm_crc_err,
    input  logic              frm_too_long,
    input  logic              frm_align_err,
    input  logic              frm_runt,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              desc_unavail,
    output logic [AW-1:0]     cur_desc,
    output logic [CNT_W-1:0]  miss_count
);
    localparam logic [AW-1:0] LINK_OFS = AW'(OFS_LINK);

    state_t state;
    frame_t pend;
    frame_t frm_in;
    logic   armed;
    logic   accept;
    logic   drop;
    logic   owned;
    logic   load_next;
    logic [STAT_W-1:0] wb_word;

    assign frm_in = '{len: frm_len, crc: frm_crc_err, too_long: frm_too_long,
                      align: frm_align_err, runt: frm_runt};

    assign accept    = armed && frm_done && (state == S_IDLE);
    assign drop      = armed && frm_done && (state != S_IDLE);
    assign owned     = (mem_rdata[OWN_HI:OWN_LO] == OWN_DMA);
    assign load_next = (state == S_LINK);

    rxring_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_enable),
        .base      (ring_base),
        .load_next (load_next),
        .next_addr (mem_rdata[AW-1:0]),
        .cur       (cur_desc),
        .armed     (armed)
    );

    rxring_miss #(.W(CNT_W)) u_miss (
        .clk   (clk),
        .rst   (rst),
        .bump  (drop),
        .count (miss_count)
    );

    rxring_fmt u_fmt (
        .frm    (pend),
        .status (wb_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            pend  <= '0;
        end else if (!rx_enable) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        pend  <= frm_in;
                        state <= S_FETCH;
                    end
                end
                S_FETCH: state <= S_CHECK;
                S_CHECK: state <= owned ? S_LINK : S_STALL;
                S_LINK:  state <= S_IDLE;
                S_STALL: begin
                    if (poll_kick) state <= S_FETCH;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        case (state)
            S_FETCH: mem_rd = 1'b1;
            S_CHECK: begin
                if (owned) begin
                    mem_rd   = 1'b1;
                    mem_addr = cur_desc + LINK_OFS;
                end
            end
            S_LINK: begin
                mem_wr    = 1'b1;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    assign desc_unavail = (state == S_STALL);
endmodule

// File: rtl/rxring_wb_chk.sv
module rxring_wb_chk #(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_enable,
    input logic [AW-1:0]    ring_base,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [31:0]      mem_wdata,
    input logic [31:0]      mem_rdata,
    input logic             desc_unavail,
    input logic [AW-1:0]    cur_desc,
    input logic [CNT_W-1:0] miss_count
);
    a_r1_read_before_write: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    a_r2_handback_owner: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata[31:30] == 2'b00 && mem_wdata[16]));

    a_r4_follow_link: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> cur_desc == $past(mem_rdata[AW-1:0]));

    a_r5_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        desc_unavail |-> (!mem_wr && !mem_rd));

    a_r7_miss_saturate: assert property (@(posedge clk) disable iff (rst)
        (miss_count == {CNT_W{1'b1}}) |=> (miss_count == {CNT_W{1'b1}}));

    a_r7_miss_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> miss_count >= $past(miss_count));

    a_r8_base_load: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_enable) |=> cur_desc == $past(ring_base));

    a_r9_no_rw_clash: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind rxring_wb rxring_wb_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_enable    (rx_enable),
    .ring_base    (ring_base),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .desc_unavail (desc_unavail),
    .cur_desc     (cur_desc),
    .miss_count   (miss_count)
);

// File: tb/rxring_wb_bench.sv
module rxring_wb_bench;
    localparam int AW    = 8;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_enable = 1'b0;
    logic [AW-1:0]    ring_base = '0;
    logic             poll_kick = 1'b0;
    logic             frm_done = 1'b0;
    logic [15:0]      frm_len = '0;
    logic             frm_crc_err = 1'b0;
    logic             frm_too_long = 1'b0;
    logic             frm_align_err = 1'b0;
    logic             frm_runt = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic             mem_rd;
    logic             mem_wr;
    logic [31:0]      mem_wdata;
    logic [31:0]      mem_rdata = '0;
    logic             desc_unavail;
    logic [AW-1:0]    cur_desc;
    logic [CNT_W-1:0] miss_count;

    logic [31:0]      mem [256];
    logic             bk_we = 1'b0;
    logic [AW-1:0]    bk_addr = '0;
    logic [31:0]      bk_data = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rxring_wb #(.AW(AW), .CNT_W(CNT_W)) u_rxring_wb (
        .clk (clk), .rst (rst), .rx_enable (rx_enable), .ring_base (ring_base),
        .poll_kick (poll_kick), .frm_done (frm_done), .frm_len (frm_len),
        .frm_crc_err (frm_crc_err), .frm_too_long (frm_too_long),
        .frm_align_err (frm_align_err), .frm_runt (frm_runt),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .desc_unavail (desc_unavail), .cur_desc (cur_desc),
        .miss_count (miss_count)
    );

    always @(posedge clk) begin
        if (bk_we) mem[bk_addr] <= bk_data;
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    typedef struct packed {
        logic [7:0]  adr;
        logic [7:0]  nxt;
        logic [15:0] len;
        logic [3:0]  err;   // {runt, align, too_long, crc}
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{adr: 8'h10, nxt: 8'h40, len: 16'h05EA, err: 4'b0000, exp: 32'h0011_05EA},
        '{adr: 8'h40, nxt: 8'h20, len: 16'h0040, err: 4'b0001, exp: 32'h0003_0040},
        '{adr: 8'h20, nxt: 8'h60, len: 16'h0800, err: 4'b0010, exp: 32'h0009_0800},
        '{adr: 8'h60, nxt: 8'h10, len: 16'h003C, err: 4'b1100, exp: 32'h0061_003C}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bk_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bk_we = 1'b1; bk_addr = a; bk_data = d;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] len, input logic [3:0] err);
        @(negedge clk);
        frm_done = 1'b1; frm_len = len;
        {frm_runt, frm_align_err, frm_too_long, frm_crc_err} = err;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        poll_kick = 1'b1;
        @(negedge clk);
        poll_kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R9: reset state
        chk("R9 cur", 32'(cur_desc), 32'h0);
        chk("R9 unavail", 32'(desc_unavail), 32'h0);
        chk("R9 miss", 32'(miss_count), 32'h0);
        chk("R9 no access", 32'({mem_rd, mem_wr}), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 4; i++) begin
            bk_write(VEC[i].adr,        32'h8000_0000);
            bk_write(VEC[i].adr + 8'd1, 32'hB000_0000 | 32'(VEC[i].adr));
            bk_write(VEC[i].adr + 8'd2, 32'hCAFE_0000 | 32'(VEC[i].adr));
            bk_write(VEC[i].adr + 8'd3, 32'(VEC[i].nxt));
        end

        @(negedge clk);
        ring_base = 8'h10; rx_enable = 1'b1;
        idle(2);
        chk("R8 base load", 32'(cur_desc), 32'h10);

        // R1 R2 R3 R4: walk the linked ring
        for (int i = 0; i < 4; i++) begin
            send(VEC[i].len, VEC[i].err);
            idle(5);
            chk("R2/R3 status", mem[VEC[i].adr], VEC[i].exp);
            chk("R4 buffer kept", mem[VEC[i].adr + 8'd1], 32'hB000_0000 | 32'(VEC[i].adr));
            chk("R4 spare kept", mem[VEC[i].adr + 8'd2], 32'hCAFE_0000 | 32'(VEC[i].adr));
            chk("R4 link kept", mem[VEC[i].adr + 8'd3], 32'(VEC[i].nxt));
            chk("R1/R4 pointer", 32'(cur_desc), 32'(VEC[i].nxt));
        end

        // R5: descriptor at 0x10 is processor-owned now
        send(16'h0100, 4'b0000);
        idle(5);
        chk("R5 unavail", 32'(desc_unavail), 32'h1);
        chk("R5 no write", mem[8'h10], 32'h0011_05EA);
        chk("R5 pointer held", 32'(cur_desc), 32'h10);

        // R7: drops while stalled
        for (int i = 0; i < 3; i++) send(16'h0001, 4'b0000);
        chk("R7 miss count", 32'(miss_count), 32'h3);
        for (int i = 0; i < 15; i++) send(16'h0001, 4'b0000);
        chk("R7 miss saturate", 32'(miss_count), 32'hF);

        // R6: poll while still processor-owned
        kick();
        idle(5);
        chk("R6 re-stall", 32'(desc_unavail), 32'h1);
        chk("R6 re-stall no write", mem[8'h10], 32'h0011_05EA);

        // R6: hand descriptor back, then poll
        bk_write(8'h10, 32'h8000_0000);
        kick();
        idle(5);
        chk("R6 held frame written", mem[8'h10], 32'h0011_0100);
        chk("R6 unavail cleared", 32'(desc_unavail), 32'h0);
        chk("R6 pointer advanced", 32'(cur_desc), 32'h40);

        // R8: disabled frames ignored
        bk_write(8'h40, 32'h8000_0000);
        @(negedge clk);
        rx_enable = 1'b0;
        send(16'h0055, 4'b0000);
        idle(5);
        chk("R8 disabled no write", mem[8'h40], 32'h8000_0000);
        chk("R8 disabled pointer", 32'(cur_desc), 32'h40);
        chk("R8 disabled miss", 32'(miss_count), 32'hF);

        // R8: re-enable with a new base
        bk_write(8'h60, 32'h8000_0000);
        @(negedge clk);
        ring_base = 8'h60; rx_enable = 1'b1;
        idle(2);
        chk("R8 reload base", 32'(cur_desc), 32'h60);
        send(16'h0123, 4'b0001);
        idle(5);
        chk("R3 crc after reload", mem[8'h60], 32'h0003_0123);
        chk("R4 pointer after reload", 32'(cur_desc), 32'h10);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule